// File: doc/BRIEF.md
# Byte-Accessed Free-Running Timer with Shadow High Byte

This block is a 16-bit up-counter that software reaches through an 8-bit port at two byte addresses. The high half of the counter is never touched directly. A holding register, the shadow, stands between the bus and the counter's upper byte, so that a 16-bit value can be read or loaded in one step while the counter keeps running. A read of the low byte returns the live low count and, on the same clock edge, captures the live upper byte into the shadow. A later read of the high address returns that captured value. A write to the high address only fills the shadow. A write to the low byte then loads both halves at once.

Software must therefore read low before high, and write high before low. If the order is reversed, the counter receives whatever the shadow held before, and the new upper value stays in the shadow until the next low write. The block keeps this behaviour exactly. A power-of-two prescaler sets the count rate. The counter can wrap as an 8-bit or a 16-bit counter, and in either mode a wrap sets a sticky overflow flag.

Top module: `shadow_timer`

## Requirements
- R1: A read with address 0 drives the live low count byte onto the read data in the same cycle, and at that clock edge the live upper count byte is copied into the shadow.
- R2: A read with address 1 returns the shadow, not the live upper count. With no read enabled the read data is zero. After reset the counter, shadow, prescaler and overflow flag are all zero.
- R3: A write with address 1 stores the data in the shadow only. The counter value is unchanged by it.
- R4: A write with address 0 loads the counter with the shadow as upper byte and the bus data as lower byte, in one clock edge.
- R5: If the low byte is written before the high byte, the counter takes the earlier shadow content as its upper byte. The new high value stays readable at address 1 until the next low write loads it.
- R6: The counter advances once every 2^psel_i clock cycles in which run_i is high, and holds while run_i is low. If psel_i is lowered below the prescaler's current count, the next cycle with run_i high produces an increment.
- R7: In 8-bit mode (mode16_i low), only the lower byte counts. It wraps from 0xFF to 0x00 and reports an overflow, and the upper byte is held.
- R8: In 16-bit mode the full counter wraps from 0xFFFF to 0x0000 and reports an overflow. A carry from 0x00FF to 0x0100 is no overflow.
- R9: The overflow flag stays set until a cycle with ovf_clr_i high clears it. A wrap in the same cycle as the clear leaves the flag set.
- R10: A write with address 0 restarts the prescaler, so that the first increment after the load comes a full 2^psel_i running cycles later.
- R11: A load from a low-byte write takes priority over an increment in the same cycle. That cycle neither increments the counter nor reports an overflow.
- R12: When a high-byte write and a low-byte read fall in the same cycle, the shadow takes the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | Write address: 0 low byte, 1 high byte (shadow) |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | Read address: 0 low byte, 1 high byte (shadow) |
| rd_data_o | output | 8 | Read data, combinational |
| run_i | input | 1 | Count enable |
| psel_i | input | 3 | Prescaler select, divide by 2^psel_i |
| mode16_i | input | 1 | 1: 16-bit counter, 0: 8-bit counter |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can land on one clock edge. The first pair is a low-byte load and a prescaler increment. The bench raises run_i and writes 0x10 to the low byte in the same cycle, with the counter at 0xFFFF and a divide-by-one prescale. It then expects 0xFF10 and no overflow. The second pair is a high-byte write and a low-byte read. The bench issues both in one cycle and expects the shadow to hold the written byte. A wrap together with a clear is also driven, and the flag must stay set. A long random phase drives all inputs, so these collisions also occur freely. A behavioural model checks the read data and the flag on every cycle.

// File: rtl/shadow_timer_pkg.sv
package shadow_timer_pkg;
  localparam logic ADDR_LO = 1'b0;
  localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/st_prescaler.sv
module st_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  localparam int PC_W = (1 << PSEL_W) - 1;

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] limit;
  logic            at_limit;

  // limit = 2^sel - 1, built bit by bit
  for (genvar i = 0; i < PC_W; i++) begin : g_limit
    assign limit[i] = (32'(sel_i) > i);
  end

  // >= so a lowered select never strands the count above the limit
  assign at_limit = (pcnt_q >= limit);
  assign tick_o   = run_i && !clr_i && at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_q <= '0;
    else if (clr_i)    pcnt_q <= '0;
    else if (run_i) begin
      if (at_limit)    pcnt_q <= '0;
      else             pcnt_q <= pcnt_q + 1'b1;
    end
  end

  AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pcnt_q == '0));  // R10
endmodule

// File: rtl/st_counter.sv
module st_counter #(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2*DATA_W-1:0] load_val_i,
  input  logic                inc_i,
  input  logic                mode16_i,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic                wrap_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full   = mode16_i ? (&cnt_q) : (&cnt_q[DATA_W-1:0]);
  assign wrap_o = inc_i && !load_i && full;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (inc_i) begin
      if (mode16_i)        cnt_q <= cnt_q + 1'b1;
      else                 cnt_q[DATA_W-1:0] <= cnt_q[DATA_W-1:0] + 1'b1;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)));  // R11
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(cnt_o));  // R6
  AST_HI_HELD_8BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode16_i && !load_i) |=> (cnt_o[CNT_W-1:DATA_W] == $past(cnt_o[CNT_W-1:DATA_W])));  // R7
endmodule

// File: rtl/shadow_timer.sv
module shadow_timer
  import shadow_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              mode16_i,
  input  logic              ovf_clr_i,
  output logic              ovf_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic             lo_wr, hi_wr, lo_rd;
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] shadow_q;
  logic             ovf_q;

  assign lo_wr = wr_en_i && (wr_addr_i == ADDR_LO);
  assign hi_wr = wr_en_i && (wr_addr_i == ADDR_HI);
  assign lo_rd = rd_en_i && (rd_addr_i == ADDR_LO);

  st_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .clr_i  (lo_wr),
    .sel_i  (psel_i),
    .tick_o (tick)
  );

  st_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (lo_wr),
    .load_val_i ({shadow_q, wr_data_i}),
    .inc_i      (tick),
    .mode16_i   (mode16_i),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  // bus write to the shadow beats the read-side capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (hi_wr)  shadow_q <= wr_data_i;
    else if (lo_rd)  shadow_q <= cnt[CNT_W-1:DATA_W];
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign ovf_o = ovf_q;

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) rd_data_o = (rd_addr_i == ADDR_HI) ? shadow_q : cnt[DATA_W-1:0];
  end

  AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd && !hi_wr) |=> (shadow_q == $past(cnt[CNT_W-1:DATA_W])));  // R1
  AST_SHADOW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> (shadow_q == $past(wr_data_i)));  // R12
  AST_HI_WR_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && !tick) |=> $stable(cnt));  // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);  // R9
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_o);  // R9
endmodule

// File: tb/shadow_timer_tb.sv
module shadow_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0, rd_addr_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       run_i = 1'b0;
  logic [2:0] psel_i = '0;
  logic       mode16_i = 1'b1;
  logic       ovf_clr_i = 1'b0;
  logic       ovf_o;

  int checks = 0, errors = 0;
  bit done = 0, model_on = 0;

  // reference state
  int m_cnt = 0, m_sh = 0, m_pc = 0, m_ovf = 0;

  always #10 clk_i = ~clk_i;

  shadow_timer u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i, .rd_addr_i, .rd_data_o, .run_i, .psel_i,
    .mode16_i, .ovf_clr_i, .ovf_o
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_sh = 0; m_pc = 0; m_ovf = 0;
    end else begin
      int  nsh, div, lo;
      bit  evt;
      evt = 0;
      div = 1 << psel_i;
      nsh = m_sh;
      if (wr_en_i && wr_addr_i)               nsh = wr_data_i;
      else if (rd_en_i && !rd_addr_i)         nsh = (m_cnt >> 8) & 8'hFF;
      if (wr_en_i && !wr_addr_i) begin
        m_cnt = m_sh * 256 + wr_data_i;
        m_pc  = 0;
      end else if (run_i) begin
        if (m_pc >= div - 1) begin
          m_pc = 0;
          if (mode16_i) begin
            if (m_cnt == 16'hFFFF) begin m_cnt = 0; evt = 1; end
            else m_cnt = m_cnt + 1;
          end else begin
            lo = m_cnt & 8'hFF;
            if (lo == 8'hFF) begin lo = 0; evt = 1; end
            else lo = lo + 1;
            m_cnt = (m_cnt & 16'hFF00) | lo;
          end
        end else m_pc = m_pc + 1;
      end
      if (evt) m_ovf = 1;
      else if (ovf_clr_i) m_ovf = 0;
      m_sh = nsh;
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk_i) begin
    if (model_on && !done) begin
      int exp_rd;
      exp_rd = !rd_en_i ? 0 : (rd_addr_i ? m_sh : (m_cnt & 8'hFF));
      checks++;
      if (rd_data_o !== 8'(exp_rd)) begin
        errors++;
        $display("FAIL %s model read: got %02h exp %02h",
                 !rd_en_i ? "R2" : (rd_addr_i ? "R2" : "R1"), rd_data_o, exp_rd[7:0]);
      end
      checks++;
      if (ovf_o !== 1'(m_ovf)) begin
        errors++;
        $display("FAIL R9 model overflow: got %0b exp %0d", ovf_o, m_ovf);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(logic a, logic [7:0] exp, string tag);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    checks++;
    if (rd_data_o !== exp) begin
      errors++;
      $display("FAIL %s read addr %0b: got %02h exp %02h", tag, a, rd_data_o, exp);
    end
    step(1);
    rd_en_i = 1'b0;
  endtask

  task automatic ovf_chk(logic exp, string tag);
    @(negedge clk_i);
    checks++;
    if (ovf_o !== exp) begin
      errors++;
      $display("FAIL %s overflow: got %0b exp %0b", tag, ovf_o, exp);
    end
    step(1);
  endtask

  task automatic run_for(int n);
    run_i = 1'b1;
    step(n);
    run_i = 1'b0;
  endtask

  task automatic clr_pulse();
    ovf_clr_i = 1'b1;
    step(1);
    ovf_clr_i = 1'b0;
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    model_on = 1;

    // R2: reset state
    rd_chk(1'b0, 8'h00, "R2");
    rd_chk(1'b1, 8'h00, "R2");
    ovf_chk(1'b0, "R2");

    // R4: ordered 16-bit load
    wr(1'b1, 8'h12); wr(1'b0, 8'h34);
    rd_chk(1'b0, 8'h34, "R4");
    rd_chk(1'b1, 8'h12, "R4");
    // R3: high write alone leaves counter; low read recaptures live high
    wr(1'b1, 8'h56);
    rd_chk(1'b0, 8'h34, "R3");
    rd_chk(1'b1, 8'h12, "R3");

    // R5: reversed order gives stale high byte
    wr(1'b0, 8'h78);
    rd_chk(1'b0, 8'h78, "R5");
    rd_chk(1'b1, 8'h12, "R5");
    wr(1'b1, 8'h9A);
    rd_chk(1'b1, 8'h9A, "R5");
    wr(1'b0, 8'hBC);
    rd_chk(1'b0, 8'hBC, "R5");
    rd_chk(1'b1, 8'h9A, "R5");

    // R6: divide by 4 over 10 running cycles -> 2
    wr(1'b1, 8'h00); wr(1'b0, 8'h00);
    psel_i = 3'd2;
    run_for(10);
    rd_chk(1'b0, 8'h02, "R6");
    // R10: low write restarts the prescaler
    wr(1'b0, 8'h00);
    run_for(3);
    rd_chk(1'b0, 8'h00, "R10");
    run_for(1);
    rd_chk(1'b0, 8'h01, "R10");
    psel_i = 3'd0;
    run_for(5);
    rd_chk(1'b0, 8'h06, "R6");
    // R6: lowering select below the running count
    psel_i = 3'd3;
    run_for(5);
    psel_i = 3'd1;
    run_for(1);
    rd_chk(1'b0, 8'h07, "R6");

    // R7: 8-bit wrap
    psel_i = 3'd0;
    mode16_i = 1'b0;
    wr(1'b1, 8'h55); wr(1'b0, 8'hFE);
    run_for(3);
    rd_chk(1'b0, 8'h01, "R7");
    rd_chk(1'b1, 8'h55, "R7");
    ovf_chk(1'b1, "R7");
    clr_pulse();
    ovf_chk(1'b0, "R9");

    // R8: 16-bit carry then wrap
    mode16_i = 1'b1;
    wr(1'b1, 8'h00); wr(1'b0, 8'hFF);
    run_for(1);
    ovf_chk(1'b0, "R8");
    rd_chk(1'b0, 8'h00, "R8");
    rd_chk(1'b1, 8'h01, "R8");
    wr(1'b1, 8'hFF); wr(1'b0, 8'hFF);
    run_for(1);
    ovf_chk(1'b1, "R8");
    rd_chk(1'b0, 8'h00, "R8");
    rd_chk(1'b1, 8'h00, "R8");

    // R9: wrap and clear in one cycle keep the flag
    clr_pulse();
    wr(1'b1, 8'hFF); wr(1'b0, 8'hFF);
    run_i = 1'b1; ovf_clr_i = 1'b1;
    step(1);
    run_i = 1'b0; ovf_clr_i = 1'b0;
    ovf_chk(1'b1, "R9");

    // R11: load beats increment, no overflow from a load
    clr_pulse();
    wr(1'b1, 8'hFF); wr(1'b0, 8'hFF);
    run_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 8'h10;
    step(1);
    run_i = 1'b0; wr_en_i = 1'b0;
    ovf_chk(1'b0, "R11");
    rd_chk(1'b0, 8'h10, "R11");
    rd_chk(1'b1, 8'hFF, "R11");

    // R12: high write and low read together
    rd_en_i = 1'b1; rd_addr_i = 1'b0;
    wr_en_i = 1'b1; wr_addr_i = 1'b1; wr_data_i = 8'h3C;
    @(negedge clk_i);
    checks++;
    if (rd_data_o !== 8'h10) begin
      errors++;
      $display("FAIL R1 read during shadow write: got %02h exp 10", rd_data_o);
    end
    step(1);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    rd_chk(1'b1, 8'h3C, "R12");

    // random phase, judged by the model each cycle
    for (int i = 0; i < 3000; i++) begin
      wr_en_i   = ($urandom % 6) == 0;
      wr_addr_i = 1'($urandom);
      wr_data_i = 8'($urandom);
      rd_en_i   = ($urandom % 3) == 0;
      rd_addr_i = 1'($urandom);
      run_i     = ($urandom % 8) != 0;
      ovf_clr_i = ($urandom % 40) == 0;
      if (($urandom % 50) == 0) psel_i = 3'($urandom % 3);
      if (($urandom % 200) == 0) mode16_i = ~mode16_i;
      step(1);
    end
    wr_en_i = 1'b0; rd_en_i = 1'b0; run_i = 1'b0; ovf_clr_i = 1'b0;
    step(2);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule